// File: doc/BRIEF.md
# GPIO Interrupt Style Detector

This block is a sixteen-line general-purpose I/O controller with a 32-bit register port. Software sets each line's drive value and direction, reads back the synchronized pin levels, and gives each line a three-bit interrupt style. The style selects one of five trigger conditions: high level, low level, rising edge, falling edge, or either edge. When a line's condition is detected, its bit in a sticky status register is set. Software clears status bits by writing ones to them.

Each status bit drives an active-high level interrupt toward a parent interrupt controller. Only thirteen lines have a parent wire. Lines 0 and 1 drive parent inputs 6 and 7. Lines 2 to 12 drive parent inputs 19 to 29. Lines 13 to 15 can latch status but raise nothing. Pins go through a two-flop synchronizer before any detection.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every line is an input (direction register all ones, `pin_oe` all zero), the output data and all style fields are zero, and every status bit is clear.
- R2: Byte offset 0x00 holds the output data and 0x04 holds the direction. A direction bit of 1 turns the line's driver off (`pin_oe` bit 0). A direction bit of 0 drives it (`pin_oe` bit 1). `pin_out` always carries the output data register.
- R3: Offset 0x08 reads the pin level after two synchronizer flops. A pin change made before clock edge k is visible after edge k+1, whatever the line's direction.
- R4: Line n below 8 keeps its style in bits [3n+2:3n] at offset 0x10. Line n from 8 to 15 keeps its style in bits [3(n-8)+2:3(n-8)] at offset 0x14. Bits [31:24] of both registers read as zero.
- R5: Style 0 sets status while the synchronized pin is high. Style 1 sets status while it is low. The set happens one edge after the synchronized value qualifies.
- R6: Style 2 triggers on a rising edge, style 3 on a falling edge and style 4 on either edge. An edge is the synchronized value differing from its value one cycle earlier. A pin change before edge k sets status at edge k+2.
- R7: Style codes 5, 6 and 7 never set a status bit.
- R8: Offset 0x0C reads the status. Writing 1 to bit n clears it and writing 0 leaves it unchanged. A level condition that still holds sets the bit again at the next edge.
- R9: If a detected event and a clearing write reach the same status bit at the same edge, the bit ends up set.
- R10: `parent_irq` bit 6 follows status bit 0 and bit 7 follows status bit 1. Bits 19 to 29 follow status bits 2 to 12. All other bits are zero, and status bits 13 to 15 appear nowhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from the registers |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Output data toward the pads |
| pin_oe | output | 16 | Per-line driver enable |
| parent_irq | output | 32 | Level interrupts to the parent controller |

## Verification
Register writes and `pin_out`/`pin_oe` respond one edge after the write strobe. The input register follows a pin two edges after it changes. Status and `parent_irq` respond two edges after a pin edge, and one edge after a level qualifies or a clear is written. The bench keeps a reference model that advances on each rising edge using only the inputs the design also sees, so each of these delays falls out of the model's own pipeline of pin samples. The model is compared against every output at each falling edge, and inputs change just after that falling edge, so every result is sampled in the cycle its latency puts it. The set-wins case is timed so that the clearing write lands on the same edge as the detected rising edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int REG_ADDR_W = 5;
   localparam logic [REG_ADDR_W-1:0] OFF_DOUT   = 5'h00;
   localparam logic [REG_ADDR_W-1:0] OFF_DIR    = 5'h04;
   localparam logic [REG_ADDR_W-1:0] OFF_PINS   = 5'h08;
   localparam logic [REG_ADDR_W-1:0] OFF_STAT   = 5'h0C;
   localparam logic [REG_ADDR_W-1:0] OFF_STY_LO = 5'h10;
   localparam logic [REG_ADDR_W-1:0] OFF_STY_HI = 5'h14;

   localparam int STYLE_W = 3;

   typedef enum logic [STYLE_W-1:0] {
      STY_HIGH = 3'd0,
      STY_LOW  = 3'd1,
      STY_RISE = 3'd2,
      STY_FALL = 3'd3,
      STY_ANY  = 3'd4
   } style_e;

   localparam int PIRQ_LINE0      = 6;
   localparam int PIRQ_LINE1      = 7;
   localparam int PIRQ_BLOCK_OFS  = 17;
   localparam int PIRQ_BLOCK_LAST = 12;

   // parent input index for a line, -1 when the line has none
   function automatic int parent_index(input int line);
      if (line == 0) return PIRQ_LINE0;
      if (line == 1) return PIRQ_LINE1;
      if (line >= 2 && line <= PIRQ_BLOCK_LAST) return line + PIRQ_BLOCK_OFS;
      return -1;
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_line_cell.sv
module gpio_line_cell
   import gpio_irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_sync,
   input  logic               style_we,
   input  logic [STYLE_W-1:0] style_wd,
   input  logic               clr,
   output logic [STYLE_W-1:0] style_q,
   output logic               status_q
);
   logic prev_q;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         style_q  <= '0;
         status_q <= 1'b0;
      end else begin
         prev_q   <= pin_sync;
         if (style_we) style_q <= style_wd;
         status_q <= (status_q & ~clr) | hit;
      end
   end

   always_comb begin
      case (style_e'(style_q))
         STY_HIGH: hit = pin_sync;
         STY_LOW:  hit = ~pin_sync;
         STY_RISE: hit = pin_sync & ~prev_q;
         STY_FALL: hit = ~pin_sync & prev_q;
         STY_ANY:  hit = pin_sync ^ prev_q;
         default:  hit = 1'b0;
      endcase
   end

   // R5
   level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (style_q == 3'd0 && pin_sync && !style_we) |=> status_q);
   // R7
   reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (style_q > 3'd4 && clr) |=> !status_q);
   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !status_q);
   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && hit) |=> status_q);
endmodule

// File: rtl/gpio_parent_map.sv
module gpio_parent_map
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int PARENT_W  = 32
) (
   input  logic [NUM_LINES-1:0] status,
   output logic [PARENT_W-1:0]  parent_irq
);
   generate
      if (PARENT_W <= PIRQ_BLOCK_LAST + PIRQ_BLOCK_OFS) begin : g_bad_width
         $error("parent interrupt vector too narrow for the line map");
      end
   endgenerate

   always_comb begin
      parent_irq = '0;
      for (int l = 0; l < NUM_LINES; l++) begin
         if (parent_index(l) >= 0) parent_irq[parent_index(l)] = status[l];
      end
   end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES     = 16,
   parameter int DATA_W        = 32,
   parameter int LINES_PER_REG = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int PARENT_W      = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   input  logic [NUM_LINES-1:0]  pin_in,
   output logic [NUM_LINES-1:0]  pin_out,
   output logic [NUM_LINES-1:0]  pin_oe,
   output logic [PARENT_W-1:0]   parent_irq
);
   localparam int STY_BITS = LINES_PER_REG * STYLE_W;

   generate
      if (STY_BITS > DATA_W) begin : g_bad_pack
         $error("style fields do not fit one register");
      end
      if (NUM_LINES > 2 * LINES_PER_REG || NUM_LINES > DATA_W) begin : g_bad_lines
         $error("too many lines for two style registers");
      end
   endgenerate

   logic [NUM_LINES-1:0]              dout_q;
   logic [NUM_LINES-1:0]              dir_q;
   logic [NUM_LINES-1:0]              pin_sync;
   logic [NUM_LINES-1:0]              status_q;
   logic [NUM_LINES-1:0][STYLE_W-1:0] style_q;
   logic [NUM_LINES-1:0]              clr_bits;
   logic [DATA_W-1:0]                 sty_lo, sty_hi;
   logic                              unused_wdata;

   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '1;
      end else if (wr_en) begin
         if (wr_addr == OFF_DOUT) dout_q <= wr_data[NUM_LINES-1:0];
         if (wr_addr == OFF_DIR)  dir_q  <= wr_data[NUM_LINES-1:0];
      end
   end

   assign pin_out  = dout_q;
   assign pin_oe   = ~dir_q;
   assign clr_bits = (wr_en && wr_addr == OFF_STAT) ? wr_data[NUM_LINES-1:0] : '0;

   gpio_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         localparam int FIELD = i % LINES_PER_REG;
         localparam logic [REG_ADDR_W-1:0] STY_OFF =
            (i < LINES_PER_REG) ? OFF_STY_LO : OFF_STY_HI;
         gpio_line_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_sync (pin_sync[i]),
            .style_we (wr_en && wr_addr == STY_OFF),
            .style_wd (wr_data[FIELD*STYLE_W +: STYLE_W]),
            .clr      (clr_bits[i]),
            .style_q  (style_q[i]),
            .status_q (status_q[i])
         );
      end
   endgenerate

   always_comb begin
      sty_lo = '0;
      sty_hi = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (i < LINES_PER_REG) sty_lo[i*STYLE_W +: STYLE_W] = style_q[i];
         else sty_hi[(i-LINES_PER_REG)*STYLE_W +: STYLE_W] = style_q[i];
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         OFF_DOUT:   rd_data[NUM_LINES-1:0] = dout_q;
         OFF_DIR:    rd_data[NUM_LINES-1:0] = dir_q;
         OFF_PINS:   rd_data[NUM_LINES-1:0] = pin_sync;
         OFF_STAT:   rd_data[NUM_LINES-1:0] = status_q;
         OFF_STY_LO: rd_data = sty_lo;
         OFF_STY_HI: rd_data = sty_hi;
         default:    rd_data = '0;
      endcase
   end

   gpio_parent_map #(.NUM_LINES(NUM_LINES), .PARENT_W(PARENT_W)) u_map (
      .status     (status_q),
      .parent_irq (parent_irq)
   );

   // R10
   parent_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(parent_irq) <= $countones(status_q));
   // R2
   drive_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFF_DIR) |=> (pin_oe == ~$past(wr_data[NUM_LINES-1:0])));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe;
   logic [31:0] parent_irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string tag = "R1";
   bit checking = 1'b0;

   // reference model state
   logic [15:0] m_s1, m_s2, m_prev, m_dout, m_dir, m_stat;
   int          m_style [16];
   int          sh_style [16];

   always #2 clk = ~clk;

   gpio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .parent_irq(parent_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_dout = '0; m_dir = '1; m_stat = '0;
         for (int l = 0; l < 16; l++) m_style[l] = 0;
      end else begin
         logic [15:0] set_v, clr_v;
         set_v = '0;
         for (int l = 0; l < 16; l++) begin
            bit s, p;
            s = m_s2[l]; p = m_prev[l];
            case (m_style[l])
               0: set_v[l] = s;
               1: set_v[l] = !s;
               2: set_v[l] = s && !p;
               3: set_v[l] = !s && p;
               4: set_v[l] = s != p;
               default: set_v[l] = 1'b0;
            endcase
         end
         clr_v = (wr_en && wr_addr == 5'h0C) ? wr_data[15:0] : 16'h0;
         m_stat = (m_stat & ~clr_v) | set_v;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
         if (wr_en) begin
            case (wr_addr)
               5'h00: m_dout = wr_data[15:0];
               5'h04: m_dir = wr_data[15:0];
               5'h10: for (int l = 0; l < 8; l++) m_style[l] = (wr_data >> (3*l)) & 7;
               5'h14: for (int l = 8; l < 16; l++) m_style[l] = (wr_data >> (3*(l-8))) & 7;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] exp_read(input logic [4:0] a);
      logic [31:0] v;
      v = '0;
      case (a)
         5'h00: v[15:0] = m_dout;
         5'h04: v[15:0] = m_dir;
         5'h08: v[15:0] = m_s2;
         5'h0C: v[15:0] = m_stat;
         5'h10: for (int l = 0; l < 8; l++) v = v | (32'(m_style[l]) << (3*l));
         5'h14: for (int l = 8; l < 16; l++) v = v | (32'(m_style[l]) << (3*(l-8)));
         default: v = '0;
      endcase
      return v;
   endfunction

   function automatic logic [31:0] exp_parent();
      logic [31:0] v;
      v = '0;
      for (int l = 0; l < 16; l++) begin
         if (l == 0) v[6] = m_stat[0];
         else if (l == 1) v[7] = m_stat[1];
         else if (l <= 12) v[l+17] = m_stat[l];
      end
      return v;
   endfunction

   // compare on every falling edge, before inputs move
   always @(negedge clk) begin
      if (checking) begin
         chk(tag, rd_data, exp_read(rd_addr));
         chk("R2", {16'h0, pin_oe}, {16'h0, ~m_dir});
         chk("R2", {16'h0, pin_out}, {16'h0, m_dout});
         chk("R10", parent_irq, exp_parent());
      end
   end

   // read-address sweep across the register map
   always @(negedge clk) begin
      #1;
      case (rd_addr)
         5'h00: rd_addr <= 5'h04;
         5'h04: rd_addr <= 5'h08;
         5'h08: rd_addr <= 5'h0C;
         5'h0C: rd_addr <= 5'h10;
         5'h10: rd_addr <= 5'h14;
         5'h14: rd_addr <= 5'h18;
         default: rd_addr <= 5'h00;
      endcase
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic pins(input logic [15:0] v);
      @(negedge clk); #1;
      pin_in = v;
   endtask

   task automatic set_style(input int line, input int code);
      logic [31:0] w;
      sh_style[line] = code;
      w = 32'hFF00_0000;
      if (line < 8) begin
         for (int l = 0; l < 8; l++) w = w | (32'(sh_style[l]) << (3*l));
         wr(5'h10, w);
      end else begin
         for (int l = 8; l < 16; l++) w = w | (32'(sh_style[l]) << (3*(l-8)));
         wr(5'h14, w);
      end
   endtask

   initial begin
      for (int l = 0; l < 16; l++) sh_style[l] = 0;
      idle(3); #1;
      rst_n = 1'b1;
      @(negedge clk);
      tag = "R1"; checking = 1'b1;
      chk("R1", {16'h0, pin_oe}, 32'h0);
      idle(8);

      tag = "R2";
      wr(5'h00, 32'h0000_A5C3);
      wr(5'h04, 32'h0000_FF00);
      idle(6);

      tag = "R3";
      pins(16'h1234);
      idle(7);
      pins(16'h0000);
      idle(4);

      tag = "R4";
      for (int l = 0; l < 16; l++) sh_style[l] = 7;
      wr(5'h10, 32'hFFFF_FFFF);
      wr(5'h14, 32'hFFFF_FFFF);
      idle(6);

      tag = "R8";
      wr(5'h0C, 32'h0000_FFFF);
      idle(4);
      wr(5'h0C, 32'h0000_0000);
      idle(3);

      tag = "R7";
      set_style(0, 5); set_style(1, 6); set_style(9, 5);
      pins(16'hFFFF); idle(4);
      pins(16'h0000); idle(4);
      pins(16'h0203); idle(6);
      chk("R7", parent_irq, 32'h0);
      pins(16'h0000); idle(4);

      tag = "R6";
      set_style(0, 2); set_style(1, 3); set_style(2, 4);
      set_style(12, 2); set_style(13, 4); set_style(15, 3);
      pins(16'h8002); idle(6);
      wr(5'h0C, 32'h0000_FFFF); idle(3);
      pins(16'h3005); idle(6);
      wr(5'h0C, 32'h0000_FFFF); idle(3);
      pins(16'h1004); idle(6);
      pins(16'h0000); idle(6);
      wr(5'h0C, 32'h0000_FFFF); idle(3);

      tag = "R5";
      set_style(3, 0); set_style(4, 1);
      idle(4);
      pins(16'h0018); idle(5);
      wr(5'h0C, 32'h0000_0018); idle(4);
      tag = "R8";
      pins(16'h0000); idle(4);
      wr(5'h0C, 32'h0000_0008); idle(4);
      set_style(3, 7); set_style(4, 7);
      wr(5'h0C, 32'h0000_FFFF); idle(4);

      tag = "R9";
      wr(5'h0C, 32'h0000_FFFF); idle(3);
      @(negedge clk); #1; pin_in[0] = 1'b1;
      @(negedge clk);
      wr(5'h0C, 32'h0000_0001);
      chk("R9", {31'h0, parent_irq[6]}, 32'h1);
      idle(4);

      tag = "R10";
      set_style(13, 0); set_style(14, 0); set_style(12, 0);
      pins(16'h7000); idle(6);
      pins(16'h0000); idle(2);
      wr(5'h0C, 32'h0000_FFFF); idle(4);

      checking = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #80000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule